// File: doc/BRIEF.md
# Sequential Divide and Square-Root Unit

This block computes one of three integer results from 32-bit two's-complement operands: a quotient, a remainder, or the floor of a square root. It works on one request at a time. A request is offered by raising `start` with `a`, `b` and a 2-bit `op`. The block takes the request on a clock edge where it is idle. It then spends a fixed sixteen clock edges on the request, whatever the operation, and finally raises `done` for one cycle with the answer on `result`.

To save area there is one compare-and-subtract datapath, and it is reused on every cycle. Division works on operand magnitudes and settles two quotient bits per cycle, using two chained restoring subtract stages. Square root uses the first of those stages and settles one root bit per cycle. A small fix-up stage applies the signs and the special cases when the last step completes.

Top module: `divsqrt_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0.
- R2: A request is accepted on a rising edge where `start` is 1 and `busy` is 0. `busy` is 1 from the following cycle until the cycle `done` is raised, and it is never 1 together with `done`. While `busy` is 1, `start`, `a`, `b` and `op` are ignored, and the answer depends only on the values sampled at acceptance.
- R3: `done` rises exactly 16 rising edges after the accepting edge and stays high for exactly one cycle.
- R4: With `op` = 2'b00, `result` is `a / b` truncated toward zero. The most negative value divided by -1 gives the most negative value.
- R5: With `op` = 2'b01, `result` is the remainder `a - b*(a/b)`, which is zero or carries the sign of `a`.
- R6: With `op` = 2'b10 and `a` non-negative, `result` is floor(sqrt(a)). `b` is ignored.
- R7: With `op` = 2'b10 and `a` negative, `result` is 0.
- R8: When `b` is 0, a quotient request returns 32'hFFFFFFFF and a remainder request returns `a`.
- R9: With `op` = 2'b11, `result` is 0 after the normal 16-edge latency.
- R10: `result` changes only on the edge that raises `done`, and it holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only when idle |
| op | input | 2 | 00 quotient, 01 remainder, 10 square root, 11 reserved |
| a | input | 32 | Dividend or radicand, signed |
| b | input | 32 | Divisor, signed |
| busy | output | 1 | A request is being worked on |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Answer of the most recent completed request |

## Verification
The bench covers every sign combination of quotient and remainder. A unit that got the sign rules wrong would return quotients rounded away from zero, or remainders that follow the divisor's sign. It also uses the most negative dividend with a divisor of -1, and divisors of zero with dividends of both signs. A missing override in either case would leak the raw magnitude result, for example 1 in place of -1. For square root it uses 0, 1, perfect squares, their neighbours, the largest positive value and negative inputs, which catch off-by-one root bits and a missing zero for negative input. During every busy period it also drives fresh operands, opcodes and `start` pulses, so a unit that re-sampled its inputs or took a second request would miscompare, as would one whose `done` came a cycle early or late.

// File: rtl/divsqrt_pkg.sv
package divsqrt_pkg;

    typedef enum logic [1:0] {
        OP_QUO  = 2'b00,
        OP_REM  = 2'b01,
        OP_SQRT = 2'b10,
        OP_RSVD = 2'b11
    } ds_op_e;

endpackage

// File: rtl/ds_operand_prep.sv
module ds_operand_prep
    import divsqrt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  ds_op_e       op_i,
    output logic [W-1:0] dvsr_o,
    output logic [W-1:0] init_o,
    output logic         neg_quo_o,
    output logic         neg_rem_o,
    output logic         div_zero_o
);

    logic [W-1:0] a_mag;
    logic [W-1:0] b_mag;

    always_comb begin
        a_mag      = a_i[W-1] ? (~a_i + 1'b1) : a_i;
        b_mag      = b_i[W-1] ? (~b_i + 1'b1) : b_i;
        neg_quo_o  = a_i[W-1] ^ b_i[W-1];
        neg_rem_o  = a_i[W-1];
        div_zero_o = (b_i == '0);
        dvsr_o     = b_mag;
        unique case (op_i)
            OP_QUO, OP_REM: init_o = a_mag;
            OP_SQRT:        init_o = a_i[W-1] ? '0 : a_i;
            default:        init_o = '0;
        endcase
    end

endmodule

// File: rtl/ds_csub.sv
module ds_csub #(
    parameter int RW = 33
) (
    input  logic [RW-1:0] x_i,
    input  logic [RW-1:0] y_i,
    output logic [RW-1:0] diff_o,
    output logic          ge_o
);

    logic [RW:0] full;

    always_comb begin
        full   = {1'b0, x_i} - {1'b0, y_i};
        diff_o = full[RW-1:0];
        ge_o   = ~full[RW];
    end

endmodule

// File: rtl/ds_iter_step.sv
module ds_iter_step #(
    parameter int W = 32,
    localparam int HW = W / 2
) (
    input  logic          is_sqrt_i,
    input  logic [W-1:0]  rem_i,
    input  logic [W-1:0]  acc_i,
    input  logic [HW-1:0] root_i,
    input  logic [W-1:0]  dvsr_i,
    output logic [W-1:0]  rem_o,
    output logic [W-1:0]  acc_o,
    output logic [HW-1:0] root_o
);

    logic [W:0] div_r1;
    logic [W:0] sq_s;
    logic [W:0] x0;
    logic [W:0] y0;
    logic [W:0] d0;
    logic       g0;
    logic [W:0] r1n;
    logic [W:0] r2;
    logic [W:0] d1;
    logic       g1;
    logic [W:0] r2n;

    // first stage: shared between the two operations
    assign div_r1 = {rem_i, acc_i[W-1]};
    assign sq_s   = {rem_i[W-2:0], acc_i[W-1:W-2]};
    assign x0     = is_sqrt_i ? sq_s : div_r1;
    assign y0     = is_sqrt_i ? (W+1)'({root_i, 2'b01}) : {1'b0, dvsr_i};

    ds_csub #(.RW(W+1)) i_stage0 (
        .x_i    (x0),
        .y_i    (y0),
        .diff_o (d0),
        .ge_o   (g0)
    );

    assign r1n = g0 ? d0 : x0;

    // second stage: division only, gives the second quotient bit
    assign r2 = {r1n[W-1:0], acc_i[W-2]};

    ds_csub #(.RW(W+1)) i_stage1 (
        .x_i    (r2),
        .y_i    ({1'b0, dvsr_i}),
        .diff_o (d1),
        .ge_o   (g1)
    );

    assign r2n = g1 ? d1 : r2;

    always_comb begin
        if (is_sqrt_i) begin
            rem_o  = r1n[W-1:0];
            acc_o  = {acc_i[W-3:0], 2'b00};
            root_o = {root_i[HW-2:0], g0};
        end else begin
            rem_o  = r2n[W-1:0];
            acc_o  = {acc_i[W-3:0], g0, g1};
            root_o = root_i;
        end
    end

endmodule

// File: rtl/ds_result_fix.sv
module ds_result_fix
    import divsqrt_pkg::*;
#(
    parameter int W = 32,
    localparam int HW = W / 2
) (
    input  ds_op_e        op_i,
    input  logic          neg_quo_i,
    input  logic          neg_rem_i,
    input  logic          div_zero_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  quo_mag_i,
    input  logic [W-1:0]  rem_mag_i,
    input  logic [HW-1:0] root_i,
    output logic [W-1:0]  result_o
);

    logic [W-1:0] quo_s;
    logic [W-1:0] rem_s;

    always_comb begin
        quo_s = neg_quo_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
        rem_s = neg_rem_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
        unique case (op_i)
            OP_QUO:  result_o = div_zero_i ? '1 : quo_s;
            OP_REM:  result_o = div_zero_i ? a_i : rem_s;
            OP_SQRT: result_o = {{(W-HW){1'b0}}, root_i};
            default: result_o = '0;
        endcase
    end

endmodule

// File: rtl/divsqrt_seq.sv
module divsqrt_seq
    import divsqrt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);

    localparam int HW    = W / 2;
    localparam int STEPS = W / 2;
    localparam int CW    = $clog2(STEPS);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        ds_op_e        op;
        logic          neg_quo;
        logic          neg_rem;
        logic          div_zero;
        logic [W-1:0]  a_keep;
        logic [W-1:0]  dvsr;
        logic [W-1:0]  rem;
        logic [W-1:0]  acc;
        logic [HW-1:0] root;
        logic [W-1:0]  result;
    } ds_state_t;

    ds_state_t s_d, s_q;

    logic [W-1:0]  prep_dvsr;
    logic [W-1:0]  prep_init;
    logic          prep_neg_quo;
    logic          prep_neg_rem;
    logic          prep_div_zero;
    logic [W-1:0]  step_rem;
    logic [W-1:0]  step_acc;
    logic [HW-1:0] step_root;
    logic [W-1:0]  fix_result;

    ds_operand_prep #(.W(W)) i_prep (
        .a_i        (a),
        .b_i        (b),
        .op_i       (ds_op_e'(op)),
        .dvsr_o     (prep_dvsr),
        .init_o     (prep_init),
        .neg_quo_o  (prep_neg_quo),
        .neg_rem_o  (prep_neg_rem),
        .div_zero_o (prep_div_zero)
    );

    ds_iter_step #(.W(W)) i_step (
        .is_sqrt_i (s_q.op == OP_SQRT),
        .rem_i     (s_q.rem),
        .acc_i     (s_q.acc),
        .root_i    (s_q.root),
        .dvsr_i    (s_q.dvsr),
        .rem_o     (step_rem),
        .acc_o     (step_acc),
        .root_o    (step_root)
    );

    ds_result_fix #(.W(W)) i_fix (
        .op_i       (s_q.op),
        .neg_quo_i  (s_q.neg_quo),
        .neg_rem_i  (s_q.neg_rem),
        .div_zero_i (s_q.div_zero),
        .a_i        (s_q.a_keep),
        .quo_mag_i  (step_acc),
        .rem_mag_i  (step_rem),
        .root_i     (step_root),
        .result_o   (fix_result)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            s_d.rem  = step_rem;
            s_d.acc  = step_acc;
            s_d.root = step_root;
            s_d.cnt  = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST) begin
                s_d.busy   = 1'b0;
                s_d.done   = 1'b1;
                s_d.result = fix_result;
            end
        end else if (start) begin
            s_d.busy     = 1'b1;
            s_d.cnt      = '0;
            s_d.op       = ds_op_e'(op);
            s_d.neg_quo  = prep_neg_quo;
            s_d.neg_rem  = prep_neg_rem;
            s_d.div_zero = prep_div_zero;
            s_d.a_keep   = a;
            s_d.dvsr     = prep_dvsr;
            s_d.rem      = '0;
            s_d.acc      = prep_init;
            s_d.root     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = s_q.busy;
    assign done   = s_q.done;
    assign result = s_q.result;

endmodule

// File: rtl/divsqrt_seq_chk.sv
module divsqrt_seq_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   op,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);

    localparam int STEPS = W / 2;
    localparam int LW    = $clog2(STEPS) + 2;
    localparam logic [LW-1:0] LIM = LW'(STEPS + 1);

    logic [LW-1:0] lat_q;
    logic [1:0]    op_cap_q;
    logic          neg_cap_q;
    logic          accept;

    assign accept = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q     <= '0;
            op_cap_q  <= '0;
            neg_cap_q <= 1'b0;
        end else if (accept) begin
            lat_q     <= '0;
            op_cap_q  <= op;
            neg_cap_q <= a[W-1];
        end else if (lat_q != LIM) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == LW'(STEPS)));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_sqrt_neg_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_cap_q == 2'b10 && neg_cap_q) |-> (result == '0));

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_cap_q == 2'b11) |-> (result == '0));

    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

endmodule

bind divsqrt_seq divsqrt_seq_chk #(.W(W)) u_chk (.*);

// File: tb/test_divsqrt_seq.sv
`timescale 1ns/1ps
module test_divsqrt_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        busy;
    logic        done;
    logic [31:0] result;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    divsqrt_seq #(.W(32)) i_divsqrt_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op     (op),
        .a      (a),
        .b      (b),
        .busy   (busy),
        .done   (done),
        .result (result)
    );

    function automatic longint isqrt(input longint v);
        longint r = 0;
        for (int k = 15; k >= 0; k--) begin
            longint t = r | (longint'(1) << k);
            if (t * t <= v) r = t;
        end
        return r;
    endfunction

    function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y,
                                          input logic [1:0] o);
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint q;
        case (o)
            2'b00: begin
                if (y == 0) return 32'hFFFF_FFFF;
                q = sx / sy;
                return q[31:0];
            end
            2'b01: begin
                if (y == 0) return x;
                q = sx % sy;
                return q[31:0];
            end
            2'b10: begin
                if (x[31]) return 32'd0;
                q = isqrt(sx);
                return q[31:0];
            end
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [31:0] x, input logic [31:0] y,
                                     input logic [1:0] o);
        case (o)
            2'b00:   return (y == 0) ? "R8 quotient by zero" : "R4 quotient";
            2'b01:   return (y == 0) ? "R8 remainder by zero" : "R5 remainder";
            2'b10:   return x[31] ? "R7 negative root" : "R6 root";
            default: return "R9 reserved";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] ta, input logic [31:0] tb, input logic [1:0] to);
        logic [31:0] e = model(ta, tb, to);
        string tg = tag_of(ta, tb, to);
        bit busy_ok = 1;
        @(negedge clk);
        a = ta; b = tb; op = to; start = 1'b1;
        check("R2 idle before request", {31'd0, busy}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            if (i > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            if (!(busy === 1'b1 && done === 1'b0)) busy_ok = 0;
            a = $urandom; b = $urandom; op = 2'($urandom); start = 1'($urandom);
        end
        check("R2 busy held and start ignored", {31'd0, busy_ok}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R3 done at 16th edge", {30'd0, busy, done}, 32'd1);
        check(tg, result, e);
        @(posedge clk);
        @(negedge clk);
        check("R3 done one cycle", {31'd0, done}, 32'd0);
        check("R10 result held", result, e);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        check("R1 done after reset", {31'd0, done}, 32'd0);
        check("R1 result after reset", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4, R5 sign combinations
        run_op(32'd100, 32'd7, 2'b00);
        run_op(-32'sd100, 32'd7, 2'b00);
        run_op(32'd100, -32'sd7, 2'b00);
        run_op(-32'sd100, -32'sd7, 2'b00);
        run_op(32'd100, 32'd7, 2'b01);
        run_op(-32'sd100, 32'd7, 2'b01);
        run_op(32'd100, -32'sd7, 2'b01);
        run_op(-32'sd100, -32'sd7, 2'b01);
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 2'b00);
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 2'b01);
        run_op(32'h7FFF_FFFF, 32'd1, 2'b00);
        run_op(32'd5, 32'd9, 2'b00);
        // R8 divide by zero
        run_op(32'd1234, 32'd0, 2'b00);
        run_op(-32'sd1234, 32'd0, 2'b00);
        run_op(-32'sd1234, 32'd0, 2'b01);
        run_op(32'd77, 32'd0, 2'b01);
        // R6, R7 roots
        run_op(32'd0, 32'd5, 2'b10);
        run_op(32'd1, 32'd0, 2'b10);
        run_op(32'd3, 32'd0, 2'b10);
        run_op(32'd4, 32'd0, 2'b10);
        run_op(32'd99, 32'd0, 2'b10);
        run_op(32'd100, 32'd0, 2'b10);
        run_op(32'h7FFF_FFFF, 32'd0, 2'b10);
        run_op(32'hFFFF_FFFF, 32'd0, 2'b10);
        run_op(32'h8000_0000, 32'd0, 2'b10);
        // R9 reserved
        run_op(32'd55, 32'd3, 2'b11);

        for (int n = 0; n < 300; n++) begin
            logic [31:0] ra = $urandom;
            logic [31:0] rb = $urandom;
            logic [1:0]  ro = 2'($urandom);
            int pick = $urandom % 8;
            if (pick == 0) rb = 32'd0;
            else if (pick < 3) rb = 32'($signed(($urandom % 17)) - 8);
            if (($urandom % 4) == 0) ra = 32'($urandom % 1000);
            run_op(ra, rb, ro);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        finished = 1;
        $finish;
    end

endmodule